// File: doc/BRIEF.md
# Serial Pattern Compare Start Detector

This block watches one serial receive line, sampled on cycles where a bit-clock enable is high. It keeps a short history of the bits it has sampled. On every new sample while it is waiting, it checks the newest N bits against a programmable pattern of up to 16 bits. When they agree, it raises a one-cycle start pulse. It then discards a programmable number of bit times and shifts in a data word of programmable length.

It is meant to sit in front of a serial receiver that has no frame-sync line and has to find its own frame boundary from the data. One example is a link that marks each frame with a fixed preamble. The pattern, pattern length, skip count and word length are plain inputs. They are held steady while a frame is in progress.

Top module: `serial_match_start`

## Requirements
- R1: After reset, and while reset is held, `start_evt` and `word_vld` are 0 and `rx_word` is 0.
- R2: `start_evt` is high for exactly one cycle, in the cycle after a sample (a cycle with `bit_en` high) at which the newest N sampled bits equal `cmp_pattern[N-1:0]`. The newest bit is compared with pattern bit 0 and the oldest with bit N-1.
- R3: Pattern bits at or above position N take no part in the compare.
- R4: No start event is raised until at least N bits have been sampled since reset or since the last `word_vld`. The history starts empty at both of those points.
- R5: A `cmp_len` of 0 is treated as 1 and values above 16 as 16. A `word_len` of 0 is treated as 1 and values above 32 as 32.
- R6: After a start event, the next `skip_bits` samples (0 to 255) are discarded before capture begins.
- R7: The next `word_len` samples are shifted in MSB first. `rx_word` is right-aligned with zeros above the word. `word_vld` pulses for one cycle after the last data sample, and `rx_word` holds its value until the next word completes.
- R8: Between a start event and the following `word_vld`, pattern matches are ignored and no further start event occurs.
- R9: Cycles with `bit_en` low change no state and produce no output event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one sample per high cycle |
| rx_bit | input | 1 | Serial receive data |
| cmp_pattern | input | 16 | Compare pattern, newest bit at bit 0 |
| cmp_len | input | 5 | Pattern length N (1..16, clamped) |
| skip_bits | input | 8 | Bit times skipped after the start event |
| word_len | input | 6 | Data word length (1..32, clamped) |
| start_evt | output | 1 | One-cycle start pulse |
| rx_word | output | 32 | Last received word, right-aligned |
| word_vld | output | 1 | One-cycle pulse when `rx_word` updates |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Pattern embedded in data.** The pattern appears inside the data field. A design that keeps comparing during capture would emit a second start pulse in the middle of the word.
- **All-zero pattern right after reset or a word end.** A design that compares against stale or reset-zero history would fire before N fresh bits have arrived.
- **Skip count extremes and clamped lengths.** Skip counts of 0 and 255, and out-of-range pattern and word lengths, are applied. Off-by-one counting would shift the captured word by one bit or end it one sample early or late.
- **Sparse enable.** Enable cycles are spread out. A design that advances on idle cycles would drift away from the reference model.

// File: rtl/sms_pkg.sv
package sms_pkg;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_SKIP  = 2'd1,
      ST_CAPT  = 2'd2
   } sms_state_e;

   // Clamp a programmed length into 1..hi.
   function automatic int unsigned sms_clamp(input int unsigned v, input int unsigned hi);
      if (v == 0)
         return 1;
      else if (v > hi)
         return hi;
      else
         return v;
   endfunction

endpackage

// File: rtl/sms_history.sv
module sms_history
   import sms_pkg::*;
#(
   parameter int PAT_W  = 16,
   parameter int PLEN_W = $clog2(PAT_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              clear,
   input  logic              rx_bit,
   input  logic [PAT_W-1:0]  pattern,
   input  logic [PLEN_W-1:0] pat_len,
   output logic              match
);

   localparam int FILL_W = $clog2(PAT_W + 1);

   logic [PAT_W-1:0]  hist_q;
   logic [PAT_W-1:0]  hist_nxt;
   logic [PAT_W-1:0]  diff;
   logic [FILL_W-1:0] fill_q;
   logic [FILL_W-1:0] fill_nxt;
   int unsigned       eff_len;

   always_comb eff_len = sms_clamp(32'(pat_len), PAT_W);

   generate
      if (PAT_W == 1) begin : g_one
         assign hist_nxt = rx_bit;
      end else begin : g_many
         assign hist_nxt = {hist_q[PAT_W-2:0], rx_bit};
      end
   endgenerate

   generate
      for (genvar i = 0; i < PAT_W; i++) begin : g_cmp
         assign diff[i] = (eff_len > i) & (hist_nxt[i] ^ pattern[i]);
      end
   endgenerate

   assign fill_nxt = (32'(fill_q) == PAT_W) ? fill_q : fill_q + 1'b1;
   assign match    = shift_en && (32'(fill_nxt) >= eff_len) && (diff == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (clear) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (shift_en) begin
         hist_q <= hist_nxt;
         fill_q <= fill_nxt;
      end
   end

   // R4
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fill_q) <= PAT_W)
      else $error("history fill count beyond pattern width");

   // R4
   fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (fill_q == '0))
      else $error("history not emptied after word end");

endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
   import sms_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             match,
   input  logic             done,
   input  logic [DLY_W-1:0] skip_bits,
   output logic             hunt_en,
   output logic             cap_en,
   output logic             clear,
   output logic             start_evt
);

   sms_state_e       state_q;
   logic [DLY_W-1:0] dcnt_q;
   logic             start_q;

   assign hunt_en   = bit_en && (state_q == ST_HUNT);
   assign cap_en    = bit_en && (state_q == ST_CAPT);
   assign clear     = done;
   assign start_evt = start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         dcnt_q  <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         case (state_q)
            ST_HUNT: begin
               if (match) begin
                  start_q <= 1'b1;
                  if (skip_bits == '0) begin
                     state_q <= ST_CAPT;
                  end else begin
                     state_q <= ST_SKIP;
                     dcnt_q  <= skip_bits;
                  end
               end
            end
            ST_SKIP: begin
               if (bit_en) begin
                  dcnt_q <= dcnt_q - 1'b1;
                  if (dcnt_q == DLY_W'(1))
                     state_q <= ST_CAPT;
               end
            end
            ST_CAPT: begin
               if (done)
                  state_q <= ST_HUNT;
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

   // R2
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !start_evt)
      else $error("start pulse longer than one cycle");

   // R6
   skip_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> (dcnt_q != '0))
      else $error("skip state with empty counter");

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && (state_q == ST_SKIP)) |=> $stable(dcnt_q))
      else $error("skip counter moved without bit enable");

endmodule

// File: rtl/sms_capture.sv
module sms_capture
   import sms_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int WLEN_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              rx_bit,
   input  logic [WLEN_W-1:0] word_len,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              word_vld
);

   localparam int CNT_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_nxt;
   logic [CNT_W-1:0]  bcnt_q;
   logic [WORD_W-1:0] word_q;
   logic              vld_q;
   int unsigned       eff_len;
   logic              last;

   always_comb eff_len = sms_clamp(32'(word_len), WORD_W);

   generate
      if (WORD_W == 1) begin : g_one
         assign sh_nxt = rx_bit;
      end else begin : g_many
         assign sh_nxt = {sh_q[WORD_W-2:0], rx_bit};
      end
   endgenerate

   assign last = (32'(bcnt_q) + 32'd1) >= eff_len;
   assign done = cap_en && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bcnt_q <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= done;
         if (cap_en) begin
            if (last) begin
               word_q <= sh_nxt;
               sh_q   <= '0;
               bcnt_q <= '0;
            end else begin
               sh_q   <= sh_nxt;
               bcnt_q <= bcnt_q + 1'b1;
            end
         end
      end
   end

   assign rx_word  = word_q;
   assign word_vld = vld_q;

   // R7
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> ((rx_word >> eff_len) == '0))
      else $error("bits above word length not zero");

   // R7
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld)
      else $error("word valid longer than one cycle");

   // R7
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q |=> ($stable(rx_word) || word_vld))
      else $error("word changed without valid strobe");

endmodule

// File: rtl/serial_match_start.sv
module serial_match_start
   import sms_pkg::*;
#(
   parameter int PAT_W  = 16,
   parameter int WORD_W = 32,
   parameter int DLY_W  = 8,
   parameter int PLEN_W = $clog2(PAT_W + 1),
   parameter int WLEN_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              rx_bit,
   input  logic [PAT_W-1:0]  cmp_pattern,
   input  logic [PLEN_W-1:0] cmp_len,
   input  logic [DLY_W-1:0]  skip_bits,
   input  logic [WLEN_W-1:0] word_len,
   output logic              start_evt,
   output logic [WORD_W-1:0] rx_word,
   output logic              word_vld
);

   generate
      if (PAT_W < 1) begin : g_bad_pat
         $error("PAT_W must be at least 1");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("WORD_W must be at least 1");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("DLY_W must be at least 1");
      end
      if (PLEN_W < $clog2(PAT_W + 1)) begin : g_bad_plen
         $error("PLEN_W too narrow for PAT_W");
      end
      if (WLEN_W < $clog2(WORD_W + 1)) begin : g_bad_wlen
         $error("WLEN_W too narrow for WORD_W");
      end
   endgenerate

   logic hunt_en;
   logic cap_en;
   logic clear;
   logic match;
   logic done;

   sms_history #(.PAT_W(PAT_W), .PLEN_W(PLEN_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (hunt_en),
      .clear    (clear),
      .rx_bit   (rx_bit),
      .pattern  (cmp_pattern),
      .pat_len  (cmp_len),
      .match    (match)
   );

   sms_ctrl #(.DLY_W(DLY_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .match     (match),
      .done      (done),
      .skip_bits (skip_bits),
      .hunt_en   (hunt_en),
      .cap_en    (cap_en),
      .clear     (clear),
      .start_evt (start_evt)
   );

   sms_capture #(.WORD_W(WORD_W), .WLEN_W(WLEN_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .rx_bit   (rx_bit),
      .word_len (word_len),
      .done     (done),
      .rx_word  (rx_word),
      .word_vld (word_vld)
   );

   // Frame-in-progress observer used only by the checks below.
   logic busy_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_q <= 1'b0;
      else if (start_evt)
         busy_q <= 1'b1;
      else if (word_vld)
         busy_q <= 1'b0;
   end

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |-> !busy_q)
      else $error("start event inside a frame");

   // R7
   vld_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> (busy_q || $past(start_evt)))
      else $error("word valid without preceding start");

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> (!start_evt && !word_vld))
      else $error("output event after idle cycle");

endmodule

// File: tb/tb_serial_match_start.sv
`timescale 1ns/1ps
module tb_serial_match_start;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        rx_bit = 1'b0;
   logic [15:0] cmp_pattern = '0;
   logic [4:0]  cmp_len = 5'd4;
   logic [7:0]  skip_bits = '0;
   logic [5:0]  word_len = 6'd8;
   logic        start_evt;
   logic [31:0] rx_word;
   logic        word_vld;

   always #2.5 clk = ~clk;

   serial_match_start dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .rx_bit      (rx_bit),
      .cmp_pattern (cmp_pattern),
      .cmp_len     (cmp_len),
      .skip_bits   (skip_bits),
      .word_len    (word_len),
      .start_evt   (start_evt),
      .rx_word     (rx_word),
      .word_vld    (word_vld)
   );

   int    total = 0;
   int    fails = 0;
   string cur_req = "R1";

   // Reference model state
   bit          hist[$];
   int          mstate = 0;
   int          dleft = 0;
   int          cnt = 0;
   logic [31:0] acc = '0;
   logic [31:0] exp_word = '0;
   logic        exp_start = 1'b0;
   logic        exp_vld = 1'b0;
   int          starts_seen = 0;
   int          words_seen = 0;
   logic [15:0] lfsr = 16'hACE1;

   function automatic int clampv(int v, int hi);
      if (v == 0) return 1;
      if (v > hi) return hi;
      return v;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act %0h exp %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      hist.delete();
      mstate = 0; dleft = 0; cnt = 0;
      acc = '0; exp_word = '0; exp_start = 1'b0; exp_vld = 1'b0;
   endtask

   task automatic model_step(logic en, logic b);
      int  n;
      int  l;
      bit  ok;
      n = clampv(int'(cmp_len), 16);
      l = clampv(int'(word_len), 32);
      exp_start = 1'b0;
      exp_vld = 1'b0;
      if (en) begin
         if (mstate == 0) begin
            hist.push_back(b);
            if (hist.size() > 16) void'(hist.pop_front());
            if (hist.size() >= n) begin
               ok = 1'b1;
               for (int i = 0; i < n; i++)
                  if (hist[hist.size()-1-i] != cmp_pattern[i]) ok = 1'b0;
               if (ok) begin
                  exp_start = 1'b1;
                  starts_seen++;
                  if (skip_bits == 0) begin
                     mstate = 2; cnt = 0; acc = '0;
                  end else begin
                     mstate = 1; dleft = int'(skip_bits);
                  end
               end
            end
         end else if (mstate == 1) begin
            dleft--;
            if (dleft == 0) begin
               mstate = 2; cnt = 0; acc = '0;
            end
         end else begin
            acc = {acc[30:0], b};
            cnt++;
            if (cnt == l) begin
               exp_word = acc;
               exp_vld = 1'b1;
               words_seen++;
               mstate = 0;
               hist.delete();
            end
         end
      end
   endtask

   task automatic tick(logic en, logic b);
      bit_en = en;
      rx_bit = b;
      model_step(en, b);
      @(negedge clk);
      check(cur_req, "start_evt", 32'(start_evt), 32'(exp_start));
      check(cur_req, "word_vld", 32'(word_vld), 32'(exp_vld));
      check(cur_req, "rx_word", rx_word, exp_word);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bit_en = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      // R1: outputs cleared while reset is held
      check("R1", "reset start_evt", 32'(start_evt), 32'd0);
      check("R1", "reset word_vld", 32'(word_vld), 32'd0);
      check("R1", "reset rx_word", rx_word, 32'd0);
      rst_n = 1'b1;
   endtask

   function automatic logic next_noise();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic send(logic [31:0] v, int nb);
      for (int i = nb - 1; i >= 0; i--) tick(1'b1, v[i]);
   endtask

   task automatic noise(int nb);
      for (int i = 0; i < nb; i++) tick(1'b1, next_noise());
   endtask

   task automatic idle(int nb);
      for (int i = 0; i < nb; i++) tick(1'b0, 1'b0);
   endtask

   task automatic expect_activity(string req, int s0, int w0);
      total++;
      if (starts_seen == s0 || words_seen == w0) begin
         fails++;
         $display("FAIL %s no frame seen act starts %0d words %0d exp >0",
                  req, starts_seen - s0, words_seen - w0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog act timeout exp finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int s0;
      int w0;
      // R1 reset state
      do_reset();

      // R2 basic match, skip, MSB-first capture
      cur_req = "R2";
      cmp_pattern = 16'h000B; cmp_len = 5'd4; skip_bits = 8'd3; word_len = 6'd8;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h1, 2); send(32'hB, 4); send(32'h5, 3); send(32'hA5, 8); noise(120);
      expect_activity("R2", s0, w0);

      // R3 pattern bits above length ignored
      cur_req = "R3";
      cmp_pattern = 16'hFFF5; cmp_len = 5'd4; skip_bits = 8'd1; word_len = 6'd12;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h5, 4); send(32'h0, 1); send(32'hC3A, 12); noise(150);
      expect_activity("R3", s0, w0);

      // R8 pattern inside data field does not restart
      cur_req = "R8";
      cmp_pattern = 16'h0005; cmp_len = 5'd3; skip_bits = 8'd0; word_len = 6'd16;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h5, 3); send(32'hAAAA, 16); send(32'h5, 3); send(32'h5555, 16);
      expect_activity("R8", s0, w0);

      // R6 skip of zero and of the maximum
      cur_req = "R6";
      cmp_pattern = 16'h0003; cmp_len = 5'd2; skip_bits = 8'd0; word_len = 6'd5;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h3, 2); noise(40);
      expect_activity("R6", s0, w0);
      skip_bits = 8'd255;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h3, 2); noise(300);
      expect_activity("R6", s0, w0);

      // R9 sparse bit enable
      cur_req = "R9";
      cmp_pattern = 16'h0009; cmp_len = 5'd4; skip_bits = 8'd2; word_len = 6'd7;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      for (int k = 0; k < 200; k++) begin
         if (k % 3 == 0) tick(1'b1, next_noise());
         else tick(1'b0, next_noise());
      end
      send(32'h9, 4); idle(5); send(32'h1234, 9); idle(4);
      expect_activity("R9", s0, w0);

      // R5 length clamping
      cur_req = "R5";
      cmp_pattern = 16'h0001; cmp_len = 5'd0; skip_bits = 8'd1; word_len = 6'd0;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h1, 1); noise(60);
      expect_activity("R5", s0, w0);
      cmp_pattern = 16'hBEEF; cmp_len = 5'd20; skip_bits = 8'd2; word_len = 6'd40;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h7, 3); send(32'hBEEF, 16); noise(36);
      expect_activity("R5", s0, w0);

      // R7 full-width word and full-length pattern
      cur_req = "R7";
      cmp_pattern = 16'h8001; cmp_len = 5'd16; skip_bits = 8'd4; word_len = 6'd32;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h8001, 16); send(32'hF, 4); send(32'hDEADBEEF, 32); idle(3);
      expect_activity("R7", s0, w0);

      // R4 zero pattern needs N fresh bits after reset and after each word
      cur_req = "R4";
      cmp_pattern = 16'h0000; cmp_len = 5'd3; skip_bits = 8'd0; word_len = 6'd2;
      do_reset();
      s0 = starts_seen; w0 = words_seen;
      send(32'h0, 2); idle(2); send(32'h0, 1); send(32'h3, 2); send(32'h0, 5); noise(40);
      expect_activity("R4", s0, w0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule